// File: doc/BRIEF.md
# Nibble-Packed Allocation Tag Store

This block keeps a 4-bit allocation tag for every 16-byte memory granule. The tags sit in a byte-wide single-port RAM, two to a byte. The even granule of a pair uses the low nibble and the odd granule uses the high nibble. A client sends one request at a time through a valid/ready handshake. The block supports three operations: read the tag of one granule, write the tag of one granule, and write one tag into two consecutive granules.

The tag to write comes from a field of a 64-bit source word. A read returns a caller-supplied 64-bit word with its tag field replaced by the stored tag. Two per-request flags mark a tag byte as having no backing storage. A read from such a byte yields tag 0, and a write to it is dropped. A store whose address is not granule-aligned is refused with a fault, and the RAM is not touched. Every request ends with a one-cycle response pulse.

Top module: `tag_store`

## Requirements
- R1: The tag of granule g is held in byte g>>1 of the RAM. Bits [3:0] hold it when g is even and bits [7:4] when g is odd. Here g is address bits [ADDR_W-1:4], so the byte index is the address shifted right by 5 and address bit 4 picks the nibble.
- R2: A load (req_op 00, and also the unused code 11) returns req_dst with bits [59:56] replaced by the stored tag. All other bits pass through unchanged.
- R3: A load with req_absent[0]=1 returns tag 0 in bits [59:56] and leaves the rest of req_dst unchanged.
- R4: A single store (req_op 01) writes req_src[59:56] into the addressed nibble. The other nibble of that byte keeps its value.
- R5: A double store (req_op 10) to an even granule writes the tag into both nibbles of the byte in one RAM write.
- R6: A double store to an odd granule writes the tag into the high nibble of byte i and the low nibble of byte i+1. The index wraps from the last byte to byte 0. The two updates are made one after the other, and the response follows the second.
- R7: A store drops its write to any byte whose storage is marked missing: req_absent[0] for byte i, req_absent[1] for byte i+1. The other byte is still written. A store never faults for this reason.
- R8: A store (single or double) with a nonzero value in address bits [3:0] responds with resp_fault=1 and changes no tag. This check comes before the storage-missing check. Loads never fault.
- R9: req_ready is 1 only while the block is idle. Each accepted request yields exactly one single-cycle resp_valid pulse, and resp_data is 0 for stores.
- R10: In the cycle after reset, req_ready=1 and resp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 00 load, 01 single store, 10 double store, 11 load |
| req_addr | input | ADDR_W | Byte address of the granule |
| req_src | input | 64 | Store source word; tag in bits [59:56] |
| req_dst | input | 64 | Load destination word to receive the tag |
| req_absent | input | 2 | Storage missing for byte i (bit 0) and byte i+1 (bit 1) |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_fault | output | 1 | Alignment fault on a store |
| resp_data | output | 64 | Load result; 0 for stores |

## Verification
The hardest case to reach is an odd-granule double store where only one of the two bytes has storage. The write to the missing byte must be dropped while its neighbour is still updated, and the index must wrap when the first byte is the last one in the RAM. The stimulus first fills every byte with known and distinct nibbles. It then walks double stores over every odd granule, including the last, and cycles through all four settings of the missing-storage flags. After each pass, a full load sweep compares every nibble with an arithmetic model.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;

    localparam int GRAN_LOG2 = 4;
    localparam int TAG_LSB   = 56;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_ST1  = 2'b01,
        OP_ST2  = 2'b10,
        OP_RSVD = 2'b11
    } tag_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RDA,
        S_MODA,
        S_RDB,
        S_MODB,
        S_FULL,
        S_RESP
    } seq_state_e;

    typedef struct packed {
        tag_op_e    op;
        logic       odd;
        logic [3:0] tag;
        logic [1:0] absent;
        logic       fault;
    } req_ctx_t;

    function automatic logic [7:0] put_nibble(logic [7:0] b, logic hi, logic [3:0] t);
        return hi ? {t, b[3:0]} : {b[7:4], t};
    endfunction

    function automatic logic [3:0] get_nibble(logic [7:0] b, logic hi);
        return hi ? b[7:4] : b[3:0];
    endfunction

endpackage

// File: rtl/tag_ram.sv
module tag_ram #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [IDX_W-1:0] addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/tag_seq.sv
module tag_seq
    import tag_store_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int G_LOG2  = GRAN_LOG2,
    parameter int T_LSB   = TAG_LSB
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [1:0]                 req_op,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [3:0]                 req_tag,
    input  logic [63:0]                req_dst,
    input  logic [1:0]                 req_absent,
    output logic                       resp_valid,
    output logic                       resp_fault,
    output logic [63:0]                resp_data,
    output logic                       ram_en,
    output logic                       ram_we,
    output logic [ADDR_W-G_LOG2-2:0]   ram_addr,
    output logic [7:0]                 ram_wdata,
    input  logic [7:0]                 ram_rdata
);
    localparam int IDX_W = ADDR_W - G_LOG2 - 1;

    seq_state_e         state;
    req_ctx_t           ctx;
    logic [IDX_W-1:0]   idx;
    logic [63:0]        dst;
    logic [3:0]         ltag;

    tag_op_e            in_op;
    logic               in_mis;
    logic               in_odd;
    seq_state_e         first_st;

    always_comb begin
        in_op  = (tag_op_e'(req_op) == OP_RSVD) ? OP_LOAD : tag_op_e'(req_op);
        in_odd = req_addr[G_LOG2];
        in_mis = (in_op != OP_LOAD) && (req_addr[G_LOG2-1:0] != '0);
        if (in_mis)
            first_st = S_RESP;
        else if (in_op == OP_ST2 && !in_odd)
            first_st = req_absent[0] ? S_RESP : S_FULL;
        else if (in_op == OP_ST2)
            first_st = !req_absent[0] ? S_RDA : (!req_absent[1] ? S_RDB : S_RESP);
        else
            first_st = req_absent[0] ? S_RESP : S_RDA;
    end

    assign req_ready = (state == S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            ctx   <= '0;
            idx   <= '0;
            dst   <= '0;
            ltag  <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    ctx.op     <= in_op;
                    ctx.odd    <= in_odd;
                    ctx.tag    <= req_tag;
                    ctx.absent <= req_absent;
                    ctx.fault  <= in_mis;
                    idx        <= req_addr[ADDR_W-1:G_LOG2+1];
                    dst        <= req_dst;
                    ltag       <= '0;
                    state      <= first_st;
                end
                S_RDA:  state <= S_MODA;
                S_MODA: begin
                    if (ctx.op == OP_LOAD) ltag <= get_nibble(ram_rdata, ctx.odd);
                    if (ctx.op == OP_ST2 && !ctx.absent[1]) state <= S_RDB;
                    else                                    state <= S_RESP;
                end
                S_RDB:  state <= S_MODB;
                S_MODB: state <= S_RESP;
                S_FULL: state <= S_RESP;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = idx;
        ram_wdata = '0;
        case (state)
            S_RDA:  ram_en = 1'b1;
            S_MODA: if (ctx.op != OP_LOAD) begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_wdata = put_nibble(ram_rdata, ctx.odd, ctx.tag);
            end
            S_RDB: begin
                ram_en   = 1'b1;
                ram_addr = idx + 1'b1;
            end
            S_MODB: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = idx + 1'b1;
                ram_wdata = put_nibble(ram_rdata, 1'b0, ctx.tag);
            end
            S_FULL: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_wdata = {ctx.tag, ctx.tag};
            end
            default: ;
        endcase
    end

    always_comb begin
        resp_valid = (state == S_RESP);
        resp_fault = resp_valid && ctx.fault;
        resp_data  = '0;
        if (resp_valid && ctx.op == OP_LOAD) begin
            resp_data = dst;
            resp_data[T_LSB +: 4] = ltag;
        end
    end
endmodule

// File: rtl/tag_store.sv
module tag_store
    import tag_store_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_src,
    input  logic [63:0]       req_dst,
    input  logic [1:0]        req_absent,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [63:0]       resp_data
);
    localparam int IDX_W = ADDR_W - GRAN_LOG2 - 1;

    logic             ram_en;
    logic             ram_we;
    logic [IDX_W-1:0] ram_addr;
    logic [7:0]       ram_wdata;
    logic [7:0]       ram_rdata;

    tag_seq #(.ADDR_W(ADDR_W), .G_LOG2(GRAN_LOG2), .T_LSB(TAG_LSB)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_tag    (req_src[TAG_LSB +: 4]),
        .req_dst    (req_dst),
        .req_absent (req_absent),
        .resp_valid (resp_valid),
        .resp_fault (resp_fault),
        .resp_data  (resp_data),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_rdata  (ram_rdata)
    );

    tag_ram #(.IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );
endmodule

// File: rtl/tag_store_chk.sv
module tag_store_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_op,
    input logic [4:0] req_addr_lo,
    input logic       req_abs0,
    input logic       resp_valid,
    input logic       resp_fault,
    input logic [3:0] resp_tag,
    input logic       ram_we
);
    logic       busy;
    logic       p_load;
    logic       p_st2_even;
    logic       p_mis;
    logic       p_abs0;
    logic [1:0] wr_cnt;
    logic       acc_load;

    assign acc_load = (req_op == 2'b00) || (req_op == 2'b11);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; p_load <= 1'b0; p_st2_even <= 1'b0;
            p_mis <= 1'b0; p_abs0 <= 1'b0; wr_cnt <= '0;
        end else if (req_valid && req_ready) begin
            busy       <= 1'b1;
            p_load     <= acc_load;
            p_st2_even <= (req_op == 2'b10) && !req_addr_lo[4];
            p_mis      <= !acc_load && (req_addr_lo[3:0] != 4'd0);
            p_abs0     <= req_abs0;
            wr_cnt     <= '0;
        end else begin
            if (resp_valid) busy <= 1'b0;
            if (ram_we && wr_cnt != 2'd3) wr_cnt <= wr_cnt + 2'd1;
        end
    end

    // R10
    reset_idle_chk: assert property (@(posedge clk) rst |=> (req_ready && !resp_valid));

    // R9
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst) resp_valid |=> !resp_valid);

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst) resp_valid |-> !req_ready);

    // R8
    fault_match_chk: assert property (@(posedge clk) disable iff (rst) resp_valid |-> (resp_fault == p_mis));

    // R8
    fault_no_write_chk: assert property (@(posedge clk) disable iff (rst) (busy && p_mis) |-> !ram_we);

    // R3
    absent_load_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && p_load && p_abs0) |-> (resp_tag == 4'd0));

    // R5
    even_one_write_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && p_st2_even) |-> (wr_cnt <= 2'd1));
endmodule

bind tag_store tag_store_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_addr_lo (req_addr[4:0]),
    .req_abs0    (req_absent[0]),
    .resp_valid  (resp_valid),
    .resp_fault  (resp_fault),
    .resp_tag    (resp_data[59:56]),
    .ram_we      (ram_we)
);

// File: tb/tag_store_test.sv
`timescale 1ns/1ps
module tag_store_test;
    localparam int AW    = 10;
    localparam int NGRAN = 1 << (AW - 4);
    localparam int NBYTE = NGRAN / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0] req_src = '0;
    logic [63:0] req_dst = '0;
    logic [1:0]  req_absent = '0;
    logic        resp_valid;
    logic        resp_fault;
    logic [63:0] resp_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic done = 1'b0;
    logic [7:0] mdl [NBYTE];
    logic [63:0] got_data;
    logic        got_fault;

    always #2.5 clk = ~clk;

    tag_store #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_src(req_src), .req_dst(req_dst),
        .req_absent(req_absent), .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_data(resp_data)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [63:0] src,
                          input logic [63:0] dst, input logic [1:0] ab);
        int n;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready when idle", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_op = op; req_addr = a; req_src = src; req_dst = dst; req_absent = ab;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 busy after accept", {63'd0, req_ready}, 64'd0);
        n = 0;
        while (!resp_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(resp_valid == 1'b1, "R9 response arrives", {63'd0, resp_valid}, 64'd1);
        got_data  = resp_data;
        got_fault = resp_fault;
        @(negedge clk);
        chk(resp_valid == 1'b0, "R9 single-cycle response", {63'd0, resp_valid}, 64'd0);
    endtask

    function automatic logic [AW-1:0] gaddr(input int g);
        return AW'(g << 4);
    endfunction

    function automatic logic [3:0] mtag(input int g);
        return (g % 2 == 1) ? mdl[g / 2][7:4] : mdl[g / 2][3:0];
    endfunction

    function automatic void mset(input int g, input logic [3:0] t);
        if (g % 2 == 1) mdl[g / 2][7:4] = t;
        else            mdl[g / 2][3:0] = t;
    endfunction

    function automatic logic [63:0] with_tag(input logic [63:0] d, input logic [3:0] t);
        logic [63:0] r;
        r = d;
        r[59:56] = t;
        return r;
    endfunction

    task automatic verify_all(input string req);
        for (int g = 0; g < NGRAN; g++) begin
            logic [63:0] d;
            d = {32'hA5C3_0F1E ^ 32'(g), 32'h1234_5678 + 32'(g * 977)};
            do_req(2'b00, gaddr(g), 64'd0, d, 2'b00);
            chk(got_data == with_tag(d, mtag(g)), req, got_data, with_tag(d, mtag(g)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1 && resp_valid == 1'b0, "R10 idle after reset",
            {62'd0, req_ready, resp_valid}, 64'd2);

        // R4 fill every granule with a single store, tag from bits [59:56]
        for (int g = 0; g < NGRAN; g++) begin
            logic [3:0] t;
            t = 4'((g * 7 + 3) % 16);
            do_req(2'b01, gaddr(g), {4'hF, t, 56'hDEAD_BEEF_0000_01} ^ 64'(g), 64'd0, 2'b00);
            mset(g, t);
            chk(got_fault == 1'b0 && got_data == 64'd0, "R4 store response", got_data, 64'd0);
        end
        // R1 R2 R4 readback of every nibble
        verify_all("R1 R2 R4 load after single stores");

        // R2 reserved op code acts as a load
        do_req(2'b11, gaddr(5), 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00);
        chk(got_data == with_tag(64'hFFFF_FFFF_FFFF_FFFF, mtag(5)), "R2 code 11 loads",
            got_data, with_tag(64'hFFFF_FFFF_FFFF_FFFF, mtag(5)));

        // R3 load with missing storage returns tag 0
        for (int g = 0; g < 8; g++) begin
            do_req(2'b00, gaddr(g), 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01);
            chk(got_data == 64'hF0FF_FFFF_FFFF_FFFF, "R3 absent load", got_data, 64'hF0FF_FFFF_FFFF_FFFF);
        end

        // R7 single store with missing storage is dropped
        for (int g = 0; g < NGRAN; g += 5) begin
            do_req(2'b01, gaddr(g), {4'h0, ~mtag(g), 56'd0}, 64'd0, 2'b01);
            chk(got_fault == 1'b0, "R7 absent store no fault", {63'd0, got_fault}, 64'd0);
        end
        verify_all("R7 absent single store leaves tags");

        // R5 double store on even granules fills the byte
        for (int g = 0; g < NGRAN; g += 2) begin
            logic [3:0] t;
            t = 4'((g * 5 + 1) % 16);
            do_req(2'b10, gaddr(g), {4'h0, t, 56'd0}, 64'd0, (g % 4 == 0) ? 2'b10 : 2'b00);
            mset(g, t);
            mset(g + 1, t);
            chk(got_fault == 1'b0, "R5 even double store", {63'd0, got_fault}, 64'd0);
        end
        // R5 even double store with byte missing writes nothing
        do_req(2'b10, gaddr(6), {4'h0, ~mtag(6), 56'd0}, 64'd0, 2'b01);
        verify_all("R5 even double store readback");

        // R6 R7 odd double store, all absent patterns, including wrap at the last byte
        for (int pass = 0; pass < 4; pass++) begin
            for (int g = 1; g < NGRAN; g += 2) begin
                logic [3:0] t;
                logic [1:0] ab;
                t  = 4'((g * 3 + pass * 11) % 16);
                ab = 2'((g / 2 + pass) % 4);
                do_req(2'b10, gaddr(g), {4'h0, t, 56'd0}, 64'd0, ab);
                if (!ab[0]) mset(g, t);
                if (!ab[1]) mset((g + 1) % NGRAN, t);
                chk(got_fault == 1'b0 && got_data == 64'd0, "R6 odd double store response", got_data, 64'd0);
            end
            verify_all("R6 R7 odd double store readback");
        end

        // R8 misaligned stores fault and change nothing; loads never fault
        for (int off = 1; off < 16; off++) begin
            do_req(2'b01, AW'(64 + off), {4'h0, ~mtag(4), 56'd0}, 64'd0, 2'b00);
            chk(got_fault == 1'b1, "R8 misaligned single store faults", {63'd0, got_fault}, 64'd1);
            do_req(2'b10, AW'(48 + off), {4'h0, ~mtag(3), 56'd0}, 64'd0, 2'(off % 4));
            chk(got_fault == 1'b1, "R8 misaligned double store faults", {63'd0, got_fault}, 64'd1);
            do_req(2'b00, AW'(64 + off), 64'd0, 64'd0, 2'b00);
            chk(got_fault == 1'b0 && got_data == with_tag(64'd0, mtag(4)), "R8 misaligned load ok",
                got_data, with_tag(64'd0, mtag(4)));
        end
        verify_all("R8 tags unchanged after faults");

        finish_run();
    end
endmodule